// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset

This block is the watchdog of a small microcontroller. A free-running counter measures the time since software last restarted it. The length of the timeout comes from a 2-bit mode input. When the count expires, the block sets an interrupt flag, and that flag drives an interrupt line when the external interrupt enable is high. If the reset path is enabled at that moment, the block then starts a fixed grace countdown. If software does not restart the counter before the countdown ends, the block emits a one-cycle chip reset request and records that a watchdog reset happened.

Software reaches the block through a small register port with two addresses. Address 0 is the control register. Address 1 is a key register that accepts an unlock sequence. The interrupt flag, the reset-enable bit and the restart strobe can change only while that unlock is open. The reset-occurred flag can be written freely.

There are two reset inputs. Power-on reset clears everything. The warm (system) reset clears the counter, the interrupt flag, any pending grace countdown and the unlock state. It keeps the reset-enable bit and the reset-occurred flag, so that software can see after a restart what caused it.

Top module: `wdt_grace`

## Requirements
- R1: After power-on, warm reset or a restart, the interrupt flag (control bit 0) is set on the 2^K-th rising clock edge. K is T0_LOG, T1_LOG, T2_LOG or T3_LOG for mode values 0, 1, 2 or 3. The count then starts again from zero.
- R2: `wd_irq` is high exactly while the interrupt flag is set and `irq_en` is high. With `irq_en` low, a timeout sets the flag but raises no interrupt.
- R3: The interrupt flag stays set until software clears it through an unlocked write. An unlocked write of 1 to control bit 0 sets the flag and so raises `wd_irq` when `irq_en` is high.
- R4: If reset-enable (control bit 2) is 1 at a timeout, `chip_rst` pulses high for exactly one cycle, GRACE clock edges after the timeout edge. This happens only if reset-enable is still 1 and no restart has occurred in between.
- R5: An unlocked write with control bit 3 set clears the count and cancels a pending grace countdown. Control bit 3 always reads 0.
- R6: While reset-enable is 0, `chip_rst` never pulses and the watchdog never sets the reset-occurred flag. The counter and interrupt flag keep working. Clearing reset-enable during a grace countdown cancels the reset.
- R7: Writes to the control register change bits 0, 2 and 3 only while the unlock is open. At other times those fields of the write are ignored.
- R8: The unlock opens when 0xAA and then 0x55 are written to the key register on consecutive cycles. It stays open for the next UNLOCK_CYC cycles, and the first control write in that time uses it up.
- R9: The reset-occurred flag (control bit 1) is set when `chip_rst` pulses. Any control write can set or clear it, and setting it causes no reset.
- R10: Power-on reset clears every control bit. Warm reset clears the interrupt flag and the count but keeps reset-enable and the reset-occurred flag. Control bits 7..4 and all key register reads are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | System reset, active low, asynchronous; keeps reset-enable and reset-occurred flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = key register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| mode | input | 2 | Timeout length select |
| irq_en | input | 1 | Watchdog interrupt enable |
| wd_irq | output | 1 | Watchdog interrupt request, level |
| chip_rst | output | 1 | Chip reset request, one-cycle pulse |

## Verification
On every cycle, the assertions check that a timeout always leaves the interrupt flag set and that the reset request is a single-cycle pulse. They also check that the pulse comes exactly GRACE cycles after the timeout that armed it and sets the reset-occurred flag. Two more properties hold on every cycle: no pulse follows a cycle with reset-enable clear, and a locked control write leaves reset-enable unchanged. Only the bench scenarios can show the exact timeout length for each mode, and the unlock rules: the broken key sequence, the window that closes after three cycles, and one use per unlock. The same holds for cancelling by restart or by clearing reset-enable, and for what the warm reset keeps compared with power-on reset.

// File: rtl/wdt_grace.sv
module wdt_grace #(
  parameter int T0_LOG     = 17,
  parameter int T1_LOG     = 20,
  parameter int T2_LOG     = 23,
  parameter int T3_LOG     = 26,
  parameter int GRACE      = 512,
  parameter int UNLOCK_CYC = 3,
  parameter logic [7:0] KEY_A = 8'hAA,
  parameter logic [7:0] KEY_B = 8'h55
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm_rst_n,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] mode,
  input  logic       irq_en,
  output logic       wd_irq,
  output logic       chip_rst
);

  localparam int CW = T3_LOG;
  localparam int GW = $clog2(GRACE + 1);
  localparam int UW = $clog2(UNLOCK_CYC + 1);

  logic          run_n;
  logic [CW-1:0] cnt, lim;
  logic [GW-1:0] gcnt;
  logic [UW-1:0] ta_cnt;
  logic          aa_seen, pend, chip_rst_q;
  logic          irq_flag, rst_en, rst_flag;
  logic          ctl_wr, key_wr, prot_wr, restart, timeout, fire;

  assign run_n   = por_n & warm_rst_n;
  assign ctl_wr  = reg_we & ~reg_addr;
  assign key_wr  = reg_we & reg_addr;
  assign prot_wr = ctl_wr & (ta_cnt != '0);
  assign restart = prot_wr & reg_wdata[3];
  assign timeout = (cnt >= lim);
  assign fire    = pend & (gcnt == GW'(1)) & rst_en & ~restart;

  always_comb begin
    case (mode)
      2'd0:    lim = CW'((64'd1 << T0_LOG) - 64'd1);
      2'd1:    lim = CW'((64'd1 << T1_LOG) - 64'd1);
      2'd2:    lim = CW'((64'd1 << T2_LOG) - 64'd1);
      default: lim = CW'((64'd1 << T3_LOG) - 64'd1);
    endcase
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      cnt        <= '0;
      aa_seen    <= 1'b0;
      ta_cnt     <= '0;
      irq_flag   <= 1'b0;
      pend       <= 1'b0;
      gcnt       <= '0;
      chip_rst_q <= 1'b0;
    end else begin
      cnt     <= (restart || timeout) ? '0 : cnt + CW'(1);
      aa_seen <= key_wr && (reg_wdata == KEY_A);

      if (key_wr && aa_seen && reg_wdata == KEY_B) ta_cnt <= UW'(UNLOCK_CYC);
      else if (ctl_wr)                             ta_cnt <= '0;
      else if (ta_cnt != '0)                       ta_cnt <= ta_cnt - UW'(1);

      if (timeout)      irq_flag <= 1'b1;
      else if (prot_wr) irq_flag <= reg_wdata[0];

      if (restart) begin
        pend <= 1'b0;
      end else if (timeout && rst_en && !pend) begin
        pend <= 1'b1;
        gcnt <= GW'(GRACE);
      end else if (pend) begin
        if (gcnt == GW'(1)) pend <= 1'b0;
        gcnt <= gcnt - GW'(1);
      end

      chip_rst_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_en   <= 1'b0;
      rst_flag <= 1'b0;
    end else begin
      if (prot_wr) rst_en <= reg_wdata[2];
      if (fire)        rst_flag <= 1'b1;
      else if (ctl_wr) rst_flag <= reg_wdata[1];
    end
  end

  assign reg_rdata = reg_addr ? 8'h00 : {5'b0, rst_en, rst_flag, irq_flag};
  assign wd_irq    = irq_flag & irq_en;
  assign chip_rst  = chip_rst_q;

endmodule

// File: rtl/wdt_grace_chk.sv
module wdt_grace_chk #(
  parameter int GRACE = 512
) (
  input logic clk,
  input logic por_n,
  input logic warm_rst_n,
  input logic timeout,
  input logic pend,
  input logic ctl_wr,
  input logic prot_wr,
  input logic irq_flag,
  input logic rst_en,
  input logic rst_flag,
  input logic chip_rst
);

  localparam int SW = $clog2(GRACE + 1) + 1;

  logic [SW-1:0] since;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) since <= '0;
    else if (!warm_rst_n) since <= '0;
    else if (timeout && rst_en && !pend) since <= '0;
    else if (since != '1) since <= since + SW'(1);
  end

  p_timeout_flag_r1: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    timeout |=> irq_flag);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    chip_rst |=> !chip_rst);

  p_grace_len_r4: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    chip_rst |-> (since == SW'(GRACE)));

  p_no_rst_disabled_r6: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    !$past(rst_en) |-> !chip_rst);

  p_locked_write_r7: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    (ctl_wr && !prot_wr) |=> $stable(rst_en));

  p_flag_on_reset_r9: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    chip_rst |-> rst_flag);

endmodule

bind wdt_grace wdt_grace_chk #(.GRACE(GRACE)) u_chk (
  .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .timeout(timeout), .pend(pend),
  .ctl_wr(ctl_wr), .prot_wr(prot_wr), .irq_flag(irq_flag), .rst_en(rst_en),
  .rst_flag(rst_flag), .chip_rst(chip_rst)
);

// File: tb/wdt_grace_test.sv
`timescale 1ns/1ps
module wdt_grace_test;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, warm_rst_n = 1'b1;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] mode = 2'd3;
  logic       irq_en = 1'b0;
  logic       wd_irq, chip_rst;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_grace #(.T0_LOG(4), .T1_LOG(5), .T2_LOG(6), .T3_LOG(10), .GRACE(512)) uut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode(mode), .irq_en(irq_en),
    .wd_irq(wd_irq), .chip_rst(chip_rst)
  );

  // {we, addr, data, expected control readback}
  localparam logic [17:0] VEC [26] = '{
    {1'b1, 1'b0, 8'h04, 8'h00}, {1'b1, 1'b1, 8'hAA, 8'h00}, {1'b1, 1'b1, 8'h55, 8'h00},
    {1'b1, 1'b0, 8'h04, 8'h04}, {1'b1, 1'b0, 8'h00, 8'h04}, {1'b1, 1'b0, 8'h02, 8'h06},
    {1'b1, 1'b0, 8'h04, 8'h04}, {1'b1, 1'b1, 8'hAA, 8'h04}, {1'b1, 1'b1, 8'h00, 8'h04},
    {1'b1, 1'b1, 8'h55, 8'h04}, {1'b1, 1'b0, 8'h00, 8'h04}, {1'b1, 1'b1, 8'hAA, 8'h04},
    {1'b1, 1'b1, 8'h55, 8'h04}, {1'b0, 1'b0, 8'h00, 8'h04}, {1'b0, 1'b0, 8'h00, 8'h04},
    {1'b1, 1'b0, 8'h00, 8'h00}, {1'b1, 1'b1, 8'hAA, 8'h00}, {1'b1, 1'b1, 8'h55, 8'h00},
    {1'b0, 1'b0, 8'h00, 8'h00}, {1'b0, 1'b0, 8'h00, 8'h00}, {1'b0, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h04, 8'h00}, {1'b1, 1'b1, 8'hAA, 8'h00}, {1'b1, 1'b1, 8'h55, 8'h00},
    {1'b1, 1'b0, 8'h0C, 8'h04}, {1'b0, 1'b0, 8'h00, 8'h04}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 1'b0;
    #1;
  endtask

  task automatic unlock();
    wr(1'b1, 8'hAA);
    wr(1'b1, 8'h55);
  endtask

  task automatic por_pulse();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 5000 && !reg_rdata[0]; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    int hits;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    #1;
    chk(reg_rdata == 8'h00 && !wd_irq && !chip_rst, "R10 reset state",
        {reg_rdata, 7'b0, wd_irq, 7'b0, chip_rst}, 32'h0);

    for (int i = 0; i < 26; i++) begin
      reg_we = VEC[i][17]; reg_addr = VEC[i][16]; reg_wdata = VEC[i][15:8];
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 1'b0;
      #1;
      chk(reg_rdata == VEC[i][7:0], $sformatf("R7 R8 R9 R5 table step %0d", i), reg_rdata, VEC[i][7:0]);
    end

    mode = 2'd0; irq_en = 1'b1;
    por_pulse();
    repeat (15) @(posedge clk);
    @(negedge clk);
    chk(reg_rdata[0] == 1'b0, "R1 mode0 before 16", reg_rdata[0], 0);
    @(posedge clk); @(negedge clk);
    chk(reg_rdata[0] == 1'b1, "R1 mode0 at 16", reg_rdata[0], 1);
    chk(wd_irq == 1'b1, "R2 irq raised", wd_irq, 1);
    irq_en = 1'b0; #1;
    chk(wd_irq == 1'b0 && reg_rdata[0], "R2 flag without irq", wd_irq, 0);

    mode = 2'd1;
    por_pulse();
    repeat (31) @(posedge clk);
    @(negedge clk);
    chk(reg_rdata[0] == 1'b0, "R1 mode1 before 32", reg_rdata[0], 0);
    @(posedge clk); @(negedge clk);
    chk(reg_rdata[0] == 1'b1, "R1 mode1 at 32", reg_rdata[0], 1);

    mode = 2'd3; irq_en = 1'b1;
    por_pulse();
    wr(1'b0, 8'h01);
    chk(wd_irq == 1'b0, "R7 locked flag set ignored", wd_irq, 0);
    unlock();
    wr(1'b0, 8'h01);
    chk(wd_irq == 1'b1, "R3 software set raises irq", wd_irq, 1);
    repeat (20) @(negedge clk);
    chk(wd_irq == 1'b1, "R3 flag held", wd_irq, 1);
    unlock();
    wr(1'b0, 8'h00);
    chk(wd_irq == 1'b0 && reg_rdata == 8'h00, "R3 software clear", reg_rdata, 0);

    mode = 2'd0; irq_en = 1'b0;
    por_pulse();
    unlock();
    wr(1'b0, 8'h04);
    wait_flag();
    repeat (511) @(posedge clk);
    @(negedge clk);
    chk(chip_rst == 1'b0, "R4 no pulse before grace end", chip_rst, 0);
    @(posedge clk); @(negedge clk);
    chk(chip_rst == 1'b1, "R4 pulse at grace end", chip_rst, 1);
    chk(reg_rdata[1] == 1'b1, "R9 flag set by reset", reg_rdata[1], 1);
    @(negedge clk);
    chk(chip_rst == 1'b0, "R4 single cycle", chip_rst, 0);
    warm_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    warm_rst_n = 1'b1; #1;
    chk(reg_rdata == 8'h06, "R10 warm reset keeps bits", reg_rdata, 8'h06);
    wr(1'b0, 8'h00);
    chk(reg_rdata == 8'h04, "R9 software clear flag", reg_rdata, 8'h04);
    wr(1'b0, 8'h02);
    chk(reg_rdata == 8'h06, "R9 software set flag", reg_rdata, 8'h06);
    hits = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (chip_rst) hits++; end
    chk(hits == 0, "R9 set flag no reset", hits, 0);
    por_pulse(); #1;
    chk(reg_rdata == 8'h00, "R10 power-on clears all", reg_rdata, 0);

    mode = 2'd3;
    por_pulse();
    unlock();
    wr(1'b0, 8'h04);
    wait_flag();
    repeat (100) @(negedge clk);
    unlock();
    wr(1'b0, 8'h0C);
    chk(reg_rdata == 8'h04, "R5 restart reads 0", reg_rdata, 8'h04);
    hits = 0;
    for (int i = 0; i < 1023; i++) begin @(negedge clk); if (chip_rst) hits++; end
    chk(hits == 0, "R5 restart cancels reset", hits, 0);
    chk(reg_rdata[0] == 1'b0, "R5 count cleared", reg_rdata[0], 0);
    @(negedge clk);
    chk(reg_rdata[0] == 1'b1, "R5 R1 timeout after restart", reg_rdata[0], 1);

    mode = 2'd0;
    por_pulse();
    unlock();
    wr(1'b0, 8'h04);
    wait_flag();
    unlock();
    wr(1'b0, 8'h00);
    hits = 0;
    for (int i = 0; i < 700; i++) begin @(negedge clk); if (chip_rst) hits++; end
    chk(hits == 0, "R6 reset disabled no pulse", hits, 0);
    chk(reg_rdata[1] == 1'b0, "R6 no reset flag", reg_rdata[1], 0);
    chk(reg_rdata[0] == 1'b1, "R6 counter still runs", reg_rdata[0], 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule